// File: doc/BRIEF.md
# SPI Register Transaction Master with Slave Flow Control

This block is a SPI bus master that runs one register access at a time against a slave device that can stall the bus. A request gives the direction, a byte count from 1 to 64 (written as count minus one), and a 24-bit register address. The master drops chip select and sends a four-byte command header. It then clocks dummy bytes until the slave signals that it is ready, moves the data bytes, and releases chip select. Write data comes in through a ready/valid handshake. Read data goes out one byte at a time on a valid strobe. A one-cycle done pulse ends each request, and an error flag beside it marks a failed access.

The slave shows it is ready by setting bit 0 of a byte it returns during the polling phase. If it never does so before a millisecond-scaled timeout, the master gives up. It releases chip select and reports the error. For a read it also hands back the requested number of bytes, all of them zero.

A slave may have gone to sleep. For this reason the first access after reset, and any access after a long quiet period, starts with a short chip-select wake pulse followed by a settling gap. All timing windows are counters scaled by a ticks-per-microsecond parameter. The serial clock comes from a fixed half-period divider.

Top module: `regxfer_spi_master`

## Requirements
- R1: The first header byte is {direction, 1, count-1}: bit 7 is 1 for a read and 0 for a write, bit 6 is always 1, and bits 5:0 hold the byte count minus one.
- R2: Header bytes two to four carry the register address, bits 23:16 first, then 15:8, then 7:0.
- R3: The bus runs in SPI mode 0. SCLK idles low, MOSI changes only while SCLK is low, MISO is sampled on the rising edge, and every byte goes most significant bit first.
- R4: After the header the master always sends at least one dummy byte of 0x00. It keeps sending them until a byte received in this phase has bit 0 set. Bits 7:1 of that byte, and the bytes received during the header, are ignored.
- R5: A write takes exactly count bytes through wr_valid/wr_ready and sends them in order. A read sends count bytes of 0x00 and presents each received byte on rd_data with one rd_valid pulse. wr_ready and rd_valid are never high together.
- R6: Chip select stays low without a break from the first header bit to the last data bit. It goes high in the cycle that done pulses, and it is high whenever req_ready is high.
- R7: If no ready byte arrives within STALL_MS milliseconds of the end of the header, the master ends the poll at the next byte boundary, releases chip select and pulses done with err=1. A failed read first emits count rd_valid pulses with rd_data=0x00. A failed write takes no write data.
- R8: The first request after reset, and any request that arrives after more than IDLE_MS milliseconds in idle, is preceded by a chip-select low pulse of at least PULSE_US microseconds with no SCLK edges. A high gap of at least SETTLE_US microseconds follows before the header. A request that arrives sooner gets no pulse.
- R9: req_ready is high only in idle. A request is taken on req_valid and req_ready, and req_ready drops in the next cycle.
- R10: err is high only together with done. A transaction that completes carries err=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Master idle, request can be taken |
| req_read | input | 1 | 1 = register read, 0 = register write |
| req_len_m1 | input | 6 | Byte count minus one (0..63) |
| req_addr | input | 24 | Register address |
| wr_data | input | 8 | Write byte |
| wr_valid | input | 1 | Write byte present |
| wr_ready | output | 1 | Master takes the write byte this cycle |
| rd_data | output | 8 | Read byte |
| rd_valid | output | 1 | One pulse per read byte |
| done | output | 1 | One-cycle end-of-transaction pulse |
| err | output | 1 | Flow-control timeout, valid with done |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Master-out serial data |
| spi_miso | input | 1 | Slave-out serial data |

## Verification
A wrong header index or byte counter shows up on MOSI within the same transaction: the header bytes come out wrong, or the number of bytes in the chip-select window is wrong. The bench model counts and decodes these directly. A poll state that misreads the ready bit either overruns into the data phase or stays stalled until the timeout, so done arrives with the wrong err and a skewed read stream. A broken idle tracker shows up at the start of the next request, as a missing or extra chip-select pulse with no SCLK edges. The bench counts these pulses and times them in cycles.

// File: rtl/regxfer_pkg.sv
package regxfer_pkg;

  localparam int LEN_W     = 6;
  localparam int ADDR_W    = 24;
  localparam int HDR_BYTES = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAKE_LO,
    ST_WAKE_GAP,
    ST_HEADER,
    ST_POLL,
    ST_DATA,
    ST_ZERO_FILL,
    ST_DONE
  } xfer_state_e;

  // Command header: index 0 is the opcode/length byte, 1..3 the address MSB first.
  function automatic logic [7:0] header_byte(input logic rd,
                                             input logic [LEN_W-1:0] len_m1,
                                             input logic [ADDR_W-1:0] addr,
                                             input logic [1:0] idx);
    logic [7:0] b;
    case (idx)
      2'd0:    b = {rd, 1'b1, len_m1};
      2'd1:    b = addr[23:16];
      2'd2:    b = addr[15:8];
      default: b = addr[7:0];
    endcase
    return b;
  endfunction

endpackage

// File: rtl/spi_byte_engine.sv
module spi_byte_engine #(
  parameter int HALF_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [7:0] tx_i,
  output logic       busy_o,
  output logic       done_o,
  output logic [7:0] rx_o,
  output logic       sclk_o,
  output logic       mosi_o,
  input  logic       miso_i
);

  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

  logic             busy_q, busy_d;
  logic             sclk_q, sclk_d;
  logic             done_q, done_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [2:0]       bit_q, bit_d;
  logic [7:0]       tx_q, tx_d;
  logic [7:0]       rx_q, rx_d;
  logic             tick;

  assign tick = (div_q == DIV_LAST);

  always_comb begin
    busy_d = busy_q;
    sclk_d = sclk_q;
    done_d = 1'b0;
    div_d  = div_q;
    bit_d  = bit_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    if (start_i && !busy_q) begin
      busy_d = 1'b1;
      sclk_d = 1'b0;
      div_d  = '0;
      bit_d  = '0;
      tx_d   = tx_i;
    end else if (busy_q) begin
      if (tick) begin
        div_d = '0;
        if (!sclk_q) begin
          sclk_d = 1'b1;
          rx_d   = {rx_q[6:0], miso_i};
        end else begin
          sclk_d = 1'b0;
          if (bit_q == 3'd7) begin
            busy_d = 1'b0;
            done_d = 1'b1;
          end else begin
            bit_d = bit_q + 3'd1;
            tx_d  = {tx_q[6:0], 1'b0};
          end
        end
      end else begin
        div_d = div_q + DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
      div_q  <= '0;
      bit_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      busy_q <= busy_d;
      sclk_q <= sclk_d;
      done_q <= done_d;
      div_q  <= div_d;
      bit_q  <= bit_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign rx_o   = rx_q;
  assign sclk_o = sclk_q;
  assign mosi_o = tx_q[7];

endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         expired_o
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)            cnt_d = val_i;
    else if (cnt_q != '0)  cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/idle_monitor.sv
module idle_monitor #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic mark_i,
  output logic wake_o
);

  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             seen_q, seen_d;

  always_comb begin
    seen_d = seen_q | mark_i;
    if (active_i)              cnt_d = '0;
    else if (cnt_q == CNT_LIM) cnt_d = cnt_q;
    else                       cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      seen_q <= seen_d;
    end
  end

  assign wake_o = !seen_q || (cnt_q == CNT_LIM);

endmodule

// File: rtl/regxfer_spi_master.sv
module regxfer_spi_master
  import regxfer_pkg::*;
#(
  parameter int SCLK_HALF    = 4,
  parameter int TICKS_PER_US = 250,
  parameter int PULSE_US     = 1,
  parameter int SETTLE_US    = 100,
  parameter int STALL_MS     = 100,
  parameter int IDLE_MS      = 900
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_read,
  input  logic [LEN_W-1:0]  req_len_m1,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        wr_data,
  input  logic              wr_valid,
  output logic              wr_ready,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  output logic              done,
  output logic              err,
  output logic              spi_sclk,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);

  localparam int TICKS_PER_MS = TICKS_PER_US * 1000;
  localparam int PULSE_T      = PULSE_US * TICKS_PER_US;
  localparam int SETTLE_T     = SETTLE_US * TICKS_PER_US;
  localparam int STALL_T      = STALL_MS * TICKS_PER_MS;
  localparam int IDLE_T       = IDLE_MS * TICKS_PER_MS;
  localparam int TMR_MAX      = (STALL_T > SETTLE_T) ?
                                ((STALL_T > PULSE_T) ? STALL_T : PULSE_T) :
                                ((SETTLE_T > PULSE_T) ? SETTLE_T : PULSE_T);
  localparam int TMR_W        = $clog2(TMR_MAX + 1);
  localparam int CNT_W        = LEN_W + 1;

  xfer_state_e       state_q, state_d;
  logic              rd_q, rd_d;
  logic [LEN_W-1:0]  len_m1_q, len_m1_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              err_q, err_d;
  logic              cs_n_q, cs_n_d;

  logic              eng_start, eng_busy, eng_done;
  logic [7:0]        eng_tx, eng_rx;
  logic              tmr_load, tmr_exp;
  logic [TMR_W-1:0]  tmr_val;
  logic              idle_mark, wake_need;
  logic              can_launch;
  logic [CNT_W-1:0]  len_full;

  spi_byte_engine #(.HALF_DIV(SCLK_HALF)) u_engine (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (eng_start),
    .tx_i    (eng_tx),
    .busy_o  (eng_busy),
    .done_o  (eng_done),
    .rx_o    (eng_rx),
    .sclk_o  (spi_sclk),
    .mosi_o  (spi_mosi),
    .miso_i  (spi_miso)
  );

  interval_timer #(.W(TMR_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (tmr_load),
    .val_i     (tmr_val),
    .expired_o (tmr_exp)
  );

  idle_monitor #(.LIMIT(IDLE_T)) u_idle (
    .clk      (clk),
    .rst_n    (rst_n),
    .active_i (state_q != ST_IDLE),
    .mark_i   (idle_mark),
    .wake_o   (wake_need)
  );

  assign len_full   = {1'b0, len_m1_q} + CNT_W'(1);
  assign can_launch = !eng_busy && !eng_done;

  always_comb begin
    state_d   = state_q;
    rd_d      = rd_q;
    len_m1_d  = len_m1_q;
    addr_d    = addr_q;
    cnt_d     = cnt_q;
    err_d     = err_q;
    eng_start = 1'b0;
    eng_tx    = 8'h00;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    idle_mark = 1'b0;
    wr_ready  = 1'b0;
    rd_valid  = 1'b0;
    rd_data   = 8'h00;

    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          rd_d      = req_read;
          len_m1_d  = req_len_m1;
          addr_d    = req_addr;
          cnt_d     = '0;
          err_d     = 1'b0;
          idle_mark = 1'b1;
          if (wake_need) begin
            state_d  = ST_WAKE_LO;
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(PULSE_T);
          end else begin
            state_d = ST_HEADER;
          end
        end
      end

      ST_WAKE_LO: begin
        if (tmr_exp) begin
          state_d  = ST_WAKE_GAP;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(SETTLE_T);
        end
      end

      ST_WAKE_GAP: begin
        if (tmr_exp) begin
          state_d = ST_HEADER;
          cnt_d   = '0;
        end
      end

      ST_HEADER: begin
        if (can_launch && (cnt_q < CNT_W'(HDR_BYTES))) begin
          eng_start = 1'b1;
          eng_tx    = header_byte(rd_q, len_m1_q, addr_q, cnt_q[1:0]);
          cnt_d     = cnt_q + CNT_W'(1);
        end
        if (eng_done && (cnt_q == CNT_W'(HDR_BYTES))) begin
          state_d  = ST_POLL;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(STALL_T);
        end
      end

      ST_POLL: begin
        if (can_launch) begin
          eng_start = 1'b1;
        end
        if (eng_done) begin
          if (eng_rx[0]) begin
            state_d = ST_DATA;
            cnt_d   = '0;
          end else if (tmr_exp) begin
            err_d   = 1'b1;
            cnt_d   = '0;
            state_d = rd_q ? ST_ZERO_FILL : ST_DONE;
          end
        end
      end

      ST_DATA: begin
        if (can_launch && (cnt_q != len_full)) begin
          if (rd_q) begin
            eng_start = 1'b1;
            cnt_d     = cnt_q + CNT_W'(1);
          end else begin
            wr_ready = 1'b1;
            if (wr_valid) begin
              eng_start = 1'b1;
              eng_tx    = wr_data;
              cnt_d     = cnt_q + CNT_W'(1);
            end
          end
        end
        if (eng_done) begin
          if (rd_q) begin
            rd_valid = 1'b1;
            rd_data  = eng_rx;
          end
          if (cnt_q == len_full) state_d = ST_DONE;
        end
      end

      ST_ZERO_FILL: begin
        rd_valid = 1'b1;
        if (cnt_q == {1'b0, len_m1_q}) state_d = ST_DONE;
        else                           cnt_d = cnt_q + CNT_W'(1);
      end

      default: begin
        state_d = ST_IDLE;
      end
    endcase

    cs_n_d = !((state_d == ST_WAKE_LO) || (state_d == ST_HEADER) ||
               (state_d == ST_POLL)    || (state_d == ST_DATA));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      rd_q     <= 1'b0;
      len_m1_q <= '0;
      addr_q   <= '0;
      cnt_q    <= '0;
      err_q    <= 1'b0;
      cs_n_q   <= 1'b1;
    end else begin
      state_q  <= state_d;
      rd_q     <= rd_d;
      len_m1_q <= len_m1_d;
      addr_q   <= addr_d;
      cnt_q    <= cnt_d;
      err_q    <= err_d;
      cs_n_q   <= cs_n_d;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign done      = (state_q == ST_DONE);
  assign err       = (state_q == ST_DONE) && err_q;
  assign spi_cs_n  = cs_n_q;

endmodule

// File: rtl/regxfer_spi_master_chk.sv
module regxfer_spi_master_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic wr_ready,
  input logic rd_valid,
  input logic done,
  input logic err,
  input logic spi_sclk,
  input logic spi_cs_n,
  input logic spi_mosi
);

  // R6
  idle_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> spi_cs_n);

  // R6
  done_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> spi_cs_n);

  // R3
  sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  // R3
  mosi_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

  // R10
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  // R9
  accept_leaves_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R6
  done_returns_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> req_ready);

  // R5
  dir_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ready && rd_valid));

endmodule

bind regxfer_spi_master regxfer_spi_master_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .wr_ready  (wr_ready),
  .rd_valid  (rd_valid),
  .done      (done),
  .err       (err),
  .spi_sclk  (spi_sclk),
  .spi_cs_n  (spi_cs_n),
  .spi_mosi  (spi_mosi)
);

// File: tb/regxfer_spi_master_bench.sv
`timescale 1ns/1ps
module regxfer_spi_master_bench;

  localparam int TPU       = 1;
  localparam int PULSE_US  = 2;
  localparam int SETTLE_US = 10;
  localparam int STALL_MS  = 1;
  localparam int IDLE_MS   = 2;

  logic        clk, rst_n;
  logic        req_valid, req_ready, req_read;
  logic [5:0]  req_len_m1;
  logic [23:0] req_addr;
  logic [7:0]  wr_data, rd_data;
  logic        wr_valid, wr_ready, rd_valid, done, err;
  logic        spi_sclk, spi_cs_n, spi_mosi, spi_miso;

  regxfer_spi_master #(
    .SCLK_HALF(2), .TICKS_PER_US(TPU), .PULSE_US(PULSE_US),
    .SETTLE_US(SETTLE_US), .STALL_MS(STALL_MS), .IDLE_MS(IDLE_MS)
  ) u_regxfer_spi_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_read(req_read), .req_len_m1(req_len_m1), .req_addr(req_addr),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .done(done), .err(err),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int total = 0;
  int fails = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // ---------------- slave model ----------------
  int          cfg_stall;
  bit          cfg_forever;
  int          cfg_seed;
  int          rise_cnt, nbytes, ep_bytes;
  int          wake_cnt, fall_cyc, wake_rise_cyc, wake_low, wake_gap;
  int          sclk_at_fall_bad;
  logic [7:0]  mosi_sh;
  logic [7:0]  mlog [0:127];

  function automatic logic [7:0] rdat(int i, int seed);
    return 8'((i * 37 + seed) & 255);
  endfunction

  function automatic logic [7:0] resp_byte(int b);
    if (b < 4)                  return 8'hFF;
    if (cfg_forever)            return 8'hFE;
    if (b < 4 + cfg_stall)      return 8'hFE;
    if (b == 4 + cfg_stall)     return 8'hF1;
    return rdat(b - 5 - cfg_stall, cfg_seed);
  endfunction

  function automatic logic miso_bit(int k);
    logic [7:0] b;
    b = resp_byte(k / 8);
    return b[7 - (k % 8)];
  endfunction

  initial begin
    spi_miso = 1'b0; rise_cnt = 0; nbytes = 0; ep_bytes = 0; wake_cnt = 0;
    fall_cyc = 0; wake_rise_cyc = -100000; wake_low = 0; wake_gap = 0;
    sclk_at_fall_bad = 0; mosi_sh = 8'h00;
    cfg_stall = 0; cfg_forever = 1'b0; cfg_seed = 0;
  end

  always @(negedge spi_cs_n) begin
    fall_cyc = cyc;
    wake_gap = cyc - wake_rise_cyc;
    if (spi_sclk !== 1'b0) sclk_at_fall_bad++;
    rise_cnt = 0;
    nbytes = 0;
    spi_miso = miso_bit(0);
  end

  always @(posedge spi_cs_n) begin
    if (rise_cnt == 0) begin
      wake_cnt++;
      wake_low = cyc - fall_cyc;
      wake_rise_cyc = cyc;
    end else begin
      ep_bytes = nbytes;
    end
  end

  always @(posedge spi_sclk) begin
    if (spi_cs_n === 1'b0) begin
      mosi_sh = {mosi_sh[6:0], spi_mosi};
      rise_cnt++;
      if ((rise_cnt % 8) == 0) begin
        if (nbytes < 128) mlog[nbytes] = mosi_sh;
        nbytes++;
      end
    end
  end

  always @(negedge spi_sclk) begin
    if (spi_cs_n === 1'b0) spi_miso = miso_bit(rise_cnt);
  end

  // ---------------- host side monitor ----------------
  logic [7:0] wbuf [0:63];
  logic [7:0] rbuf [0:127];
  int  wr_idx, wr_hs, rcnt;
  bit  hs_flag, done_seen, err_seen;

  always @(negedge clk) begin
    if (hs_flag) begin
      wr_idx++;
      wr_hs++;
    end
    wr_data = wbuf[wr_idx & 63];
    hs_flag = wr_valid && wr_ready;
    if (rd_valid) begin
      if (rcnt < 128) rbuf[rcnt] = rd_data;
      rcnt++;
    end
    if (done) begin
      done_seen = 1'b1;
      err_seen  = err;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic run_txn(input bit rd, input int len, input logic [23:0] addr,
                         input int stall, input bit forever_, input int seed);
    int t;
    cfg_stall = stall; cfg_forever = forever_; cfg_seed = seed;
    for (int i = 0; i < 64; i++) wbuf[i] = 8'((i * 11 + seed + 5) & 255);
    wr_idx = 0; wr_hs = 0; rcnt = 0; hs_flag = 1'b0;
    done_seen = 1'b0; err_seen = 1'b0; ep_bytes = 0;
    @(negedge clk);
    wr_valid   = !rd;
    req_valid  = 1'b1;
    req_read   = rd;
    req_len_m1 = 6'(len - 1);
    req_addr   = addr;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk_eq("R9 req_ready low after accept", int'(req_ready), 0);
    t = 0;
    while (!done_seen && t < 20000) begin
      @(negedge clk);
      t++;
    end
    wr_valid = 1'b0;
    @(negedge clk);
    chk_eq("R6 done observed", int'(done_seen), 1);
    chk_eq("R6 cs high after done", int'(spi_cs_n), 1);
  endtask

  task automatic check_ok_txn(input bit rd, input int len, input logic [23:0] addr,
                              input int stall, input int seed);
    logic [7:0] h0;
    bit hdr_ok, poll_ok, data_ok;
    h0 = {rd, 1'b1, 6'(len - 1)};
    chk_eq("R1 header opcode/length byte", int'(mlog[0]), int'(h0));
    chk_eq("R2 address bytes MSB first",
           int'({mlog[1], mlog[2], mlog[3]}), int'(addr));
    poll_ok = 1'b1;
    for (int i = 0; i <= stall; i++) if (mlog[4 + i] != 8'h00) poll_ok = 1'b0;
    chk_eq("R4 poll dummy bytes are zero", int'(poll_ok), 1);
    chk_eq("R6 bytes inside one cs window", ep_bytes, 4 + stall + 1 + len);
    chk_eq("R10 err clear on success", int'(err_seen), 0);
    data_ok = 1'b1;
    if (rd) begin
      chk_eq("R5 read byte count", rcnt, len);
      for (int i = 0; i < len; i++) if (rbuf[i] != rdat(i, seed)) data_ok = 1'b0;
      chk_eq("R5 read data matches slave", int'(data_ok), 1);
    end else begin
      chk_eq("R5 write handshakes", wr_hs, len);
      for (int i = 0; i < len; i++) if (mlog[5 + stall + i] != wbuf[i]) data_ok = 1'b0;
      chk_eq("R5 write bytes on MOSI", int'(data_ok), 1);
    end
    hdr_ok = (sclk_at_fall_bad == 0);
    chk_eq("R3 sclk low at cs fall", int'(hdr_ok), 1);
  endtask

  task automatic t_reset;
    chk_eq("R9 reset req_ready", int'(req_ready), 1);
    chk_eq("R6 reset cs_n", int'(spi_cs_n), 1);
    chk_eq("R3 reset sclk", int'(spi_sclk), 0);
    chk_eq("R10 reset done", int'(done), 0);
  endtask

  task automatic t_first_write_wake;
    run_txn(1'b0, 4, 24'hABCDEF, 2, 1'b0, 9);
    check_ok_txn(1'b0, 4, 24'hABCDEF, 2, 9);
    chk_eq("R8 wake pulse on first access", wake_cnt, 1);
    chk(wake_low >= PULSE_US * TPU, "R8 wake pulse width", wake_low, PULSE_US * TPU);
    chk(wake_gap >= SETTLE_US * TPU, "R8 settle gap", wake_gap, SETTLE_US * TPU);
  endtask

  task automatic t_quick_read;
    run_txn(1'b1, 3, 24'h000F04, 0, 1'b0, 3);
    check_ok_txn(1'b1, 3, 24'h000F04, 0, 3);
    chk_eq("R8 no wake when recently active", wake_cnt, 1);
  endtask

  task automatic t_max_read;
    run_txn(1'b1, 64, 24'h123456, 1, 1'b0, 77);
    check_ok_txn(1'b1, 64, 24'h123456, 1, 77);
  endtask

  task automatic t_single_write;
    run_txn(1'b0, 1, 24'hFEDCBA, 5, 1'b0, 40);
    check_ok_txn(1'b0, 1, 24'hFEDCBA, 5, 40);
  endtask

  task automatic t_timeout_read;
    bit zero_ok;
    run_txn(1'b1, 2, 24'h000018, 0, 1'b1, 0);
    chk_eq("R7 read timeout err", int'(err_seen), 1);
    chk_eq("R7 read timeout byte count", rcnt, 2);
    zero_ok = (rbuf[0] == 8'h00) && (rbuf[1] == 8'h00);
    chk_eq("R7 read timeout zero data", int'(zero_ok), 1);
    chk(ep_bytes >= 5, "R7 polled before giving up", ep_bytes, 5);
  endtask

  task automatic t_timeout_write;
    run_txn(1'b0, 3, 24'h000024, 0, 1'b1, 1);
    chk_eq("R7 write timeout err", int'(err_seen), 1);
    chk_eq("R7 write timeout takes no data", wr_hs, 0);
  endtask

  task automatic t_idle_wake;
    int w0;
    w0 = wake_cnt;
    repeat (IDLE_MS * TPU * 1000 + 400) @(negedge clk);
    run_txn(1'b1, 2, 24'h00F000, 0, 1'b0, 5);
    check_ok_txn(1'b1, 2, 24'h00F000, 0, 5);
    chk_eq("R8 wake after long idle", wake_cnt, w0 + 1);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_read = 1'b0; req_len_m1 = '0;
    req_addr = '0; wr_valid = 1'b0; wr_data = 8'h00;
    wr_idx = 0; wr_hs = 0; rcnt = 0; hs_flag = 1'b0; done_seen = 1'b0; err_seen = 1'b0;
    for (int i = 0; i < 64; i++) wbuf[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    wake_cnt = 0;
    sclk_at_fall_bad = 0;
    t_reset();
    t_first_write_wake();
    t_quick_read();
    t_max_read();
    t_single_write();
    t_timeout_read();
    t_timeout_write();
    t_idle_wake();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule